// File: doc/BRIEF.md
# Watchdog Timer with Reset or NMI Action

This block is a watchdog timer for a small microcontroller. Software reaches it through an 8-bit register bus with two addresses. The control register turns the watchdog on, picks one of four power-of-two time-out lengths and chooses the action taken on a time-out. The restart register lets software reload the counter before it expires by writing a fixed key byte.

Once enabled, the watchdog stays on until the external system reset. On a time-out it sets a sticky cause flag. It then does one of two things. It can drive a reset pulse exactly 64 clocks wide, and in that case it returns its own enable, action and period fields to their reset values while keeping the flag. Or it can emit a one-cycle NMI and restart its count. A parameter shortens every period by the same power of two so that short runs can cover all four lengths.

Top module: `wdog_ctrl`

## Requirements
- R1: After the external reset (rst_n low), the control register reads 0x00 and both outputs are low. While the enable bit (bit 7) is 0, no time-out ever occurs.
- R2: Once bit 7 has been written as 1, later control writes cannot clear it. Only rst_n or a reset-mode time-out clears it.
- R3: Control bits [1:0] select the period. Codes 0, 1, 2 and 3 select 2^(18-S), 2^(22-S), 2^(25-S) and 2^(27-S) clocks, where S is PERIOD_SHIFT. The time-out takes effect on the clock edge that number of cycles after the enabling write's edge.
- R4: A time-out sets the cause flag, which reads at control bit 3.
- R5: A control read (bus_addr 0, bus_we 0) returns the flag and then clears it. A control write with bit 3 set also clears it. A time-out in the same cycle wins over either clear.
- R6: With control bit 2 set to 1 (NMI action), a time-out raises nmi_o for exactly one cycle, keeps rst_pulse_o low, and restarts the count, so the next NMI comes one period later.
- R7: With control bit 2 set to 0 (reset action, the reset default), a time-out drives rst_pulse_o high for exactly 64 cycles. The enable, action and period fields return to 0 while the flag stays at 1.
- R8: A write of the key 0xA5 to address 1 restarts the count from zero. A write of any other value there is ignored.
- R9: Control bits 6 to 4 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External system reset, active low, clears all state |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = restart register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| rst_pulse_o | output | 1 | 64-cycle reset request on time-out |
| nmi_o | output | 1 | One-cycle NMI on time-out |

## Verification
Read data is combinational, so the bench samples it during the access cycle, before the edge that clears the flag. The time-out registers its outputs on the edge that lies one full period after the edge which enabled or restarted the counter. For that reason the bench checks that nmi_o and rst_pulse_o are low in the cycle before that edge and high in the cycle after it. The reset pulse is checked at its first cycle, at its 64th cycle and in the cycle after it ends. The auto-restarted NMI is checked at one cycle after the first NMI and at exactly one period after it. All sampling happens at the falling edge, with inputs also driven there.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned EXP_MAX = 27;
    localparam logic [7:0] KICK_KEY = 8'hA5;
    localparam int unsigned PULSE_LEN = 64;

    // control register bit positions
    localparam int unsigned B_EN   = 7;
    localparam int unsigned B_FLAG = 3;
    localparam int unsigned B_NMI  = 2;

    function automatic int unsigned period_exp(input logic [1:0] code);
        case (code)
            2'd0:    return 18;
            2'd1:    return 22;
            2'd2:    return 25;
            default: return 27;
        endcase
    endfunction

endpackage

// File: rtl/wdog_limit.sv
module wdog_limit #(
    parameter int unsigned SHIFT = 0,
    parameter int unsigned CW    = wdog_pkg::EXP_MAX - SHIFT
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] term
);
    logic [CW:0] span;

    always_comb begin
        span = (CW+1)'(1) << (wdog_pkg::period_exp(code) - SHIFT);
        term = CW'(span - (CW+1)'(1));
    end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned LEN = 64,
    localparam int unsigned PW = $clog2(LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    typedef struct packed {
        logic          on;
        logic [PW-1:0] cnt;
    } pstate_t;

    pstate_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (p_q.on) begin
            p_d.cnt = p_q.cnt + PW'(1);
            if (p_q.cnt == PW'(LEN - 1)) begin
                p_d.on  = 1'b0;
                p_d.cnt = '0;
            end
        end else if (start) begin
            p_d.on  = 1'b1;
            p_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active = p_q.on;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
    parameter int unsigned PERIOD_SHIFT = 0,
    localparam int unsigned CW = wdog_pkg::EXP_MAX - PERIOD_SHIFT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       rst_pulse_o,
    output logic       nmi_o
);
    import wdog_pkg::*;

    typedef struct packed {
        logic          en;
        logic          nmi_sel;
        logic [1:0]    period;
        logic          flag;
        logic          nmi;
        logic [CW-1:0] cnt;
    } wstate_t;

    wstate_t s_d, s_q;
    logic [CW-1:0] term;
    logic ctl_wr, ctl_rd, kick, tmo, pulse_start;
    logic en_q, flag_q;

    wdog_limit #(.SHIFT(PERIOD_SHIFT), .CW(CW)) u_limit (
        .code (s_q.period),
        .term (term)
    );

    always_comb begin
        ctl_wr = bus_en && bus_we && !bus_addr;
        ctl_rd = bus_en && !bus_we && !bus_addr;
        kick   = bus_en && bus_we && bus_addr && (bus_wdata == KICK_KEY);
        tmo    = s_q.en && (s_q.cnt == term);
        pulse_start = tmo && !s_q.nmi_sel;

        s_d = s_q;
        s_d.nmi = 1'b0;

        if (ctl_wr) begin
            if (bus_wdata[B_EN]) s_d.en = 1'b1;
            s_d.nmi_sel = bus_wdata[B_NMI];
            s_d.period  = bus_wdata[1:0];
            if (bus_wdata[B_FLAG]) s_d.flag = 1'b0;
        end
        if (ctl_rd) s_d.flag = 1'b0;

        if (!s_q.en)   s_d.cnt = '0;
        else if (tmo)  s_d.cnt = '0;
        else if (kick) s_d.cnt = '0;
        else           s_d.cnt = s_q.cnt + CW'(1);

        if (tmo) begin
            s_d.flag = 1'b1;
            if (s_q.nmi_sel) begin
                s_d.nmi = 1'b1;
            end else begin
                s_d.en      = 1'b0;
                s_d.nmi_sel = 1'b0;
                s_d.period  = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pulse_start),
        .active (rst_pulse_o)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (!bus_addr)
            bus_rdata = {s_q.en, 3'b000, s_q.flag, s_q.nmi_sel, s_q.period};
    end

    assign nmi_o  = s_q.nmi;
    assign en_q   = s_q.en;
    assign flag_q = s_q.flag;
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en_q,
    input logic flag_q,
    input logic tmo,
    input logic nmi_o,
    input logic rst_pulse_o
);
    logic [6:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hcnt <= '0;
        else if (rst_pulse_o) hcnt <= hcnt + 7'd1;
        else                  hcnt <= '0;
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !nmi_o);

    p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !tmo) |=> en_q);

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> flag_q);

    p_nmi_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o);

    p_nmi_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |-> !$rose(rst_pulse_o));

    p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= 7'd64);

    p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse_o) |-> (hcnt == 7'd64));
endmodule

bind wdog_ctrl wdog_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_q        (en_q),
    .flag_q      (flag_q),
    .tmo         (tmo),
    .nmi_o       (nmi_o),
    .rst_pulse_o (rst_pulse_o)
);

// File: tb/tb_wdog_ctrl.sv
module tb_wdog_ctrl;
    localparam int unsigned SHIFT = 14;
    localparam int unsigned NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{
        8'h84, 8'h80, 8'h85, 8'h81, 8'h86, 8'h82, 8'h87, 8'h83
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic rst_pulse_o, nmi_o;
    int checks = 0, errors = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    wdog_ctrl #(.PERIOD_SHIFT(SHIFT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_pulse_o(rst_pulse_o), .nmi_o(nmi_o)
    );

    function automatic int unsigned plen(input logic [1:0] c);
        int unsigned e;
        case (c)
            2'd0: e = 18;
            2'd1: e = 22;
            2'd2: e = 25;
            default: e = 27;
        endcase
        return 1 << (e - SHIFT);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rdc(output logic [7:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_n(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned L;
        int nmi_seen;
        logic [7:0] c;

        // Reset state
        wait_n(2);
        chk("R1 reset rdata", bus_rdata, 8'h00);
        chk("R1 reset nmi", nmi_o, 1'b0);
        chk("R1 reset pulse", rst_pulse_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: every period under both actions
        for (int v = 0; v < NVEC; v++) begin
            c = VEC[v];
            L = plen(c[1:0]);
            do_reset();
            wr(1'b0, c);
            wait_n(L - 1);
            chk("R3 before time-out nmi", nmi_o, 1'b0);
            chk("R3 before time-out pulse", rst_pulse_o, 1'b0);
            @(negedge clk);
            if (c[2]) begin
                chk("R6 nmi at time-out", nmi_o, 1'b1);
                chk("R6 no reset pulse", rst_pulse_o, 1'b0);
                @(negedge clk);
                chk("R6 nmi single cycle", nmi_o, 1'b0);
                wait_n(L - 2);
                chk("R6 before restart time-out", nmi_o, 1'b0);
                @(negedge clk);
                chk("R6 auto restart nmi", nmi_o, 1'b1);
                rdc(rd);
                chk("R4 flag after nmi", rd, 32'(c | 8'h08));
            end else begin
                chk("R7 pulse first cycle", rst_pulse_o, 1'b1);
                chk("R7 nmi stays low", nmi_o, 1'b0);
                wait_n(63);
                chk("R7 pulse cycle 64", rst_pulse_o, 1'b1);
                @(negedge clk);
                chk("R7 pulse ended", rst_pulse_o, 1'b0);
                rdc(rd);
                chk("R7 R4 fields cleared, flag kept", rd, 8'h08);
                rdc(rd);
                chk("R5 flag cleared by read", rd, 8'h00);
            end
        end

        // R1: disabled counter does not time out
        do_reset();
        wr(1'b0, 8'h04);
        nmi_seen = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (nmi_o || rst_pulse_o) nmi_seen++;
        end
        chk("R1 no time-out while disabled", nmi_seen, 0);

        // R9: upper bits ignored
        wr(1'b0, 8'h7F);
        rdc(rd);
        chk("R9 unused bits read zero", rd, 8'h07);

        // R2: enable lock
        do_reset();
        wr(1'b0, 8'h84);
        wr(1'b0, 8'h00);
        rdc(rd);
        chk("R2 enable stays set", rd, 8'h80);

        // R5: write-1 clears flag
        do_reset();
        L = plen(2'd0);
        wr(1'b0, 8'h84);
        wait_n(L);
        chk("R5 setup nmi", nmi_o, 1'b1);
        wr(1'b0, 8'h8C);
        rdc(rd);
        chk("R5 flag cleared by write of 1", rd, 8'h84);

        // R8: correct key restarts the count
        do_reset();
        wr(1'b0, 8'h84);
        wait_n(10);
        wr(1'b1, 8'hA5);
        wait_n(L - 1);
        chk("R8 key restart delays time-out", nmi_o, 1'b0);
        @(negedge clk);
        chk("R8 time-out after restart", nmi_o, 1'b1);

        // R8: wrong key ignored
        do_reset();
        wr(1'b0, 8'h84);
        wait_n(4);
        wr(1'b1, 8'h5A);
        wait_n(L - 6);
        chk("R8 wrong key before time-out", nmi_o, 1'b0);
        @(negedge clk);
        chk("R8 wrong key ignored", nmi_o, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule